// File: doc/BRIEF.md
# SDRAM Single-Rank Command Controller

This block turns single-word read and write requests from a host port into the command stream for one rank of single-data-rate SDRAM. The rank has four internal banks, 13-bit row addresses and 10-bit column addresses. After reset the controller waits out the power-up interval and brings the memory up. It closes all banks, issues eight refreshes and then programs the mode register. From then on it serves host requests and inserts an auto-refresh whenever the refresh interval expires.

Every request opens a row, issues one column command and closes the row again. Each access is therefore self-contained, so any bank and row can follow any other. All spacings between commands are whole clock counts. They are derived from nanosecond limits and a clock-period parameter as ceil(t/tCK). Read data comes back on its own valid pulse, a fixed number of cycles after the READ command. That number depends on the programmed CAS latency of 2 or 3.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset is released, the command pins show NOP (CS#,RAS#,CAS#,WE# = 0111) for at least ceil(100 µs / tCK) cycles. The first command is PRECHARGE (0010) with address bit 10 high, issued while CKE is high.
- R2: During start-up the order is: one PRECHARGE-all, then exactly eight AUTO REFRESH (0001), then one MODE REGISTER SET (0000). The first refresh comes at least tRP after the precharge, and each refresh is at least tRC after the previous one. No ACTIVE (0011) is issued before the mode register set.
- R3: The mode register set puts the following on the address pins: burst length 1 (bits 2:0 = 000), sequential wrap (bit 3 = 0), the CAS latency in bits 6:4, and zeros elsewhere. The next command follows at least 2 cycles later.
- R4: host_ready is low until start-up completes and while a refresh sequence is in progress. A request accepted with host_valid and host_ready high on a rising edge is followed in the very next cycle by ACTIVE.
- R5: The host word address splits into column = bits 9:0, bank = bits 11:10 and row = bits 24:12. ACTIVE carries the row and bank, and the column command carries the column and bank. Requests are served in acceptance order.
- R6: READ (0101) or WRITE (0100) comes at least tRCD cycles after ACTIVE, to the open bank, with address bit 10 low.
- R7: Every accessed row is closed with a single-bank PRECHARGE (bit 10 low). It comes at least tRAS after ACTIVE and at least 2 cycles after the WRITE data.
- R8: ACTIVE comes at least tRP after any PRECHARGE and at least tRC after the previous ACTIVE, and only when no bank is open.
- R9: After start-up, refreshes are never more than the refresh interval (7.8 µs) plus the time to finish one access apart. Each refresh is preceded by PRECHARGE-all with tRP spacing, and the host waits tRC after it.
- R10: The data bus is driven only in the cycle of a WRITE command. That cycle carries the request data, with each byte-mask bit equal to the inverse of the corresponding byte-enable bit.
- R11: A READ drives the byte masks low. rd_valid pulses for one cycle, CAS latency + 1 cycles after the READ command cycle, and carries the word the memory returned.
- R12: While reset is held, CKE is low, the command is NOP, and host_ready, rd_valid and the data-bus enable are low. Outside the commands listed above, the command pins show NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Request accepted on this edge when valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | Word address {row, bank, column} |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables for the write |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data word |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_ba | output | 2 | Bank select |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Read data from memory |

## Verification
The hardest situation to reach is a refresh deadline that falls while a request is waiting or half served. The controller must finish the open access and close the row. It then has to hold the host off through the precharge-all, the refresh and the tRC recovery. To get there, the stimulus streams hundreds of back-to-back requests over a small address set across several refresh intervals. Deadlines therefore land at every phase of an access. A long idle stretch afterwards exercises refresh with no traffic. A behavioural memory model in the bench stores the written bytes and returns read data after the CAS latency, so every read also checks the address split and the byte masking.

// File: rtl/sdrc_pkg.sv
// Shared types and helpers for the SDRAM command controller.
// Assumes command code order {CS#,RAS#,CAS#,WE#}.
package sdrc_pkg;
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_t;

    typedef enum logic [2:0] {
        ST_POWER, ST_INIT_REF, ST_IDLE, ST_REF, ST_COL, ST_PRE
    } ctl_state_t;

    // Minimum spacing in whole cycles: ceil(t / tCK)
    function automatic int ps_to_cyc(input int t_ps, input int tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sdrc_pwrup_timer.sv
// Power-up hold-off: raises done once CYCLES clocks have passed since reset.
// Assumes CYCLES >= 1; done stays high until the next reset.
module sdrc_pwrup_timer #(
    parameter int CYCLES = 13334
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Count up to the hold-off limit, then latch done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_q == CW'(CYCLES - 1)) done <= 1'b1;
            else cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdrc_refresh_timer.sv
// Refresh deadline: sets due every INTERVAL clocks while run is high;
// ack clears it. An expiry in the same cycle as ack keeps due set.
module sdrc_refresh_timer #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt_q;

    // Free-running interval counter with a sticky pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else if (run) begin
            if (cnt_q == CW'(INTERVAL - 1)) begin
                cnt_q <= '0;
                due   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdrc_rd_capture.sv
// Read return path: issue is high in the edge that launches READ; the word
// on dq_in is captured CAS_LAT+1 edges later and flagged with valid.
// Assumes one beat per READ (burst length 1).
module sdrc_rd_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int DEPTH = CAS_LAT + 1;
    logic [DEPTH-1:0] pipe_q;

    // Delay line tracking outstanding READ beats
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[DEPTH-2:0], issue};
    end

    // Sample the bus in the cycle the memory presents the beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= pipe_q[DEPTH-1];
            if (pipe_q[DEPTH-1]) data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
// SDRAM single-rank command controller. Runs the start-up script
// (hold-off, precharge-all, eight refreshes, mode set), then serves
// single-word host requests with a closed-row policy and inserts
// auto-refresh on deadline. Assumes COL_W <= 10 so address bit 10 is free
// for the precharge-all flag; burst length is programmed to 1.
module sdram_cmd_ctrl
    import sdrc_pkg::*;
#(
    parameter int TCK_PS    = 7500,
    parameter int CAS_LAT   = 3,
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BANK_W    = 2,
    parameter int INIT_REFS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_valid,
    output logic                            host_ready,
    input  logic                            host_we,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]               host_wdata,
    input  logic [DATA_W/8-1:0]             host_be,
    output logic                            rd_valid,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [DATA_W/8-1:0]             sd_dqm,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int BE_W   = DATA_W / 8;
    localparam int T_RCD  = ps_to_cyc(20000, TCK_PS);
    localparam int T_RP   = ps_to_cyc(20000, TCK_PS);
    localparam int T_RAS  = ps_to_cyc(45000, TCK_PS);
    localparam int T_RC   = ps_to_cyc(67500, TCK_PS);
    localparam int T_MRD  = 2;
    localparam int T_WR   = 2;
    localparam int T_INIT = ps_to_cyc(100_000_000, TCK_PS);
    localparam int T_REFI = 7_800_000 / TCK_PS;
    localparam int G_WR_PRE  = max2(T_WR, T_RAS - T_RCD);
    localparam int G_RD_PRE  = max2(1, T_RAS - T_RCD);
    localparam int G_WR_NEXT = max2(T_RP, T_RC - T_RCD - G_WR_PRE);
    localparam int G_RD_NEXT = max2(T_RP, T_RC - T_RCD - G_RD_PRE);
    localparam int WAIT_W = $clog2(T_RC + T_RAS + T_RP + T_MRD + T_WR + 1);
    localparam int REF_W  = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
    localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);

    ctl_state_t           state_q;
    sd_cmd_t              cmd_q;
    logic [WAIT_W-1:0]    wait_q;
    logic [REF_W-1:0]     refs_q;
    logic                 req_we_q;
    logic [ROW_W-1:0]     req_row_q;
    logic [BANK_W-1:0]    req_bank_q;
    logic [COL_W-1:0]     req_col_q;
    logic [DATA_W-1:0]    req_data_q;
    logic [BE_W-1:0]      req_be_q;
    logic                 pwr_done, ref_due, ref_ack, issue_rd, timer_run;

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign host_ready = (state_q == ST_IDLE) && (wait_q == '0) && !ref_due;
    assign ref_ack    = (state_q == ST_REF) && (wait_q == '0);
    assign issue_rd   = (state_q == ST_COL) && (wait_q == '0) && !req_we_q;
    assign timer_run  = (state_q != ST_POWER) && (state_q != ST_INIT_REF);

    sdrc_pwrup_timer #(.CYCLES(T_INIT)) u_pwr (
        .clk(clk), .rst_n(rst_n), .done(pwr_done)
    );

    sdrc_refresh_timer #(.INTERVAL(T_REFI)) u_refi (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .ack(ref_ack), .due(ref_due)
    );

    sdrc_rd_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .issue(issue_rd), .dq_in(sd_dq_in),
        .valid(rd_valid), .data(rd_data)
    );

    // Clock enable rises with the first clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) sd_cke <= 1'b0;
        else        sd_cke <= 1'b1;
    end

    // Command sequencer: one command per wait expiry, NOP otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_POWER;
            cmd_q      <= CMD_NOP;
            wait_q     <= '0;
            refs_q     <= '0;
            req_we_q   <= 1'b0;
            req_row_q  <= '0;
            req_bank_q <= '0;
            req_col_q  <= '0;
            req_data_q <= '0;
            req_be_q   <= '0;
            sd_addr    <= '0;
            sd_ba      <= '0;
            sd_dqm     <= '0;
            sd_dq_out  <= '0;
            sd_dq_oe   <= 1'b0;
        end else begin
            cmd_q    <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            if (wait_q != '0) wait_q <= wait_q - 1'b1;
            case (state_q)
                ST_POWER: if (pwr_done) begin
                    cmd_q   <= CMD_PRE;
                    sd_addr <= ALL_BANKS;
                    wait_q  <= WAIT_W'(T_RP - 1);
                    state_q <= ST_INIT_REF;
                end
                ST_INIT_REF: if (wait_q == '0) begin
                    if (refs_q == REF_W'(INIT_REFS)) begin
                        cmd_q   <= CMD_MRS;
                        sd_addr <= MODE_WORD;
                        sd_ba   <= '0;
                        wait_q  <= WAIT_W'(T_MRD - 1);
                        state_q <= ST_IDLE;
                    end else begin
                        cmd_q  <= CMD_REF;
                        refs_q <= refs_q + 1'b1;
                        wait_q <= WAIT_W'(T_RC - 1);
                    end
                end
                ST_IDLE: if (wait_q == '0) begin
                    if (ref_due) begin
                        cmd_q   <= CMD_PRE;
                        sd_addr <= ALL_BANKS;
                        wait_q  <= WAIT_W'(T_RP - 1);
                        state_q <= ST_REF;
                    end else if (host_valid) begin
                        req_we_q   <= host_we;
                        req_col_q  <= host_addr[COL_W-1:0];
                        req_bank_q <= host_addr[COL_W +: BANK_W];
                        req_row_q  <= host_addr[COL_W+BANK_W +: ROW_W];
                        req_data_q <= host_wdata;
                        req_be_q   <= host_be;
                        cmd_q      <= CMD_ACT;
                        sd_addr    <= host_addr[COL_W+BANK_W +: ROW_W];
                        sd_ba      <= host_addr[COL_W +: BANK_W];
                        wait_q     <= WAIT_W'(T_RCD - 1);
                        state_q    <= ST_COL;
                    end
                end
                ST_REF: if (wait_q == '0) begin
                    cmd_q   <= CMD_REF;
                    wait_q  <= WAIT_W'(T_RC - 1);
                    state_q <= ST_IDLE;
                end
                ST_COL: if (wait_q == '0) begin
                    cmd_q     <= req_we_q ? CMD_WR : CMD_RD;
                    sd_addr   <= ROW_W'(req_col_q);
                    sd_ba     <= req_bank_q;
                    sd_dqm    <= req_we_q ? ~req_be_q : '0;
                    sd_dq_out <= req_data_q;
                    sd_dq_oe  <= req_we_q;
                    wait_q    <= req_we_q ? WAIT_W'(G_WR_PRE - 1) : WAIT_W'(G_RD_PRE - 1);
                    state_q   <= ST_PRE;
                end
                ST_PRE: if (wait_q == '0) begin
                    cmd_q   <= CMD_PRE;
                    sd_addr <= '0;
                    sd_ba   <= req_bank_q;
                    wait_q  <= req_we_q ? WAIT_W'(G_WR_NEXT - 1) : WAIT_W'(G_RD_NEXT - 1);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_POWER;
            endcase
        end
    end
endmodule

// File: rtl/sdrc_chk.sv
// Timing and handshake checker for sdram_cmd_ctrl, attached by bind.
// Keeps saturating cycle counters since the last ACTIVE and PRECHARGE.
module sdrc_chk
    import sdrc_pkg::*;
#(
    parameter int TCK_PS = 7500
) (
    input logic clk,
    input logic rst_n,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dq_oe,
    input logic host_valid,
    input logic host_ready,
    input logic rd_valid
);
    localparam int C_RCD = ps_to_cyc(20000, TCK_PS);
    localparam int C_RP  = ps_to_cyc(20000, TCK_PS);
    localparam int C_RC  = ps_to_cyc(67500, TCK_PS);

    logic [3:0] cmd;
    logic [7:0] since_act, since_pre;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Cycles elapsed since the last ACTIVE / PRECHARGE, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 8'hFF;
            since_pre <= 8'hFF;
        end else begin
            if (cmd == CMD_ACT) since_act <= 8'd1;
            else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
            if (cmd == CMD_PRE) since_pre <= 8'd1;
            else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
        end
    end

    // R6
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= 8'(C_RCD));
    // R8
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> since_pre >= 8'(C_RP));
    // R8
    rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> since_act >= 8'(C_RC));
    // R10
    oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR));
    // R11
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R4
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> (cmd == CMD_ACT));
endmodule

bind sdram_cmd_ctrl sdrc_chk #(.TCK_PS(TCK_PS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe),
    .host_valid(host_valid), .host_ready(host_ready), .rd_valid(rd_valid)
);

// File: tb/sim_sdram_cmd_ctrl.sv
// Bench: behavioural memory and timing model checked on every falling edge.
module sim_sdram_cmd_ctrl;
    localparam int TCK = 7500;
    localparam int CL  = 2;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int E_RCD  = cdiv(20000, TCK);
    localparam int E_RP   = cdiv(20000, TCK);
    localparam int E_RAS  = cdiv(45000, TCK);
    localparam int E_RC   = cdiv(67500, TCK);
    localparam int E_MRD  = 2;
    localparam int E_WR   = 2;
    localparam int E_INIT = cdiv(100_000_000, TCK);
    localparam int E_REFI = 7_800_000 / TCK;

    logic clk = 0, rst_n = 0;
    logic host_valid = 0, host_we = 0;
    logic [24:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic host_ready, rd_valid;
    logic [31:0] rd_data;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic [3:0]  sd_dqm;
    logic [31:0] sd_dq_out;
    logic [31:0] sd_dq_in = '0;

    sdram_cmd_ctrl #(.TCK_PS(TCK), .CAS_LAT(CL)) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_be(host_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    always #5 clk = ~clk;

    typedef struct { bit we; logic [24:0] a; logic [31:0] d; logic [3:0] be; } req_t;
    typedef struct { int due; logic [31:0] d; } beat_t;

    req_t  reqq[$];
    beat_t drvq[$];
    beat_t expq[$];
    logic [31:0] mem [logic [24:0]];
    logic [31:0] sb  [logic [24:0]];

    int checks = 0, fails = 0, cyc = 0;
    int last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000;
    int last_mrs = -1000, ref_anchor = 0, init_refs = 0, post_refs = 0;
    bit first_done = 0, mrs_seen = 0, after_mrs = 0, ref_seq = 0, open = 0;
    logic [1:0] open_ba = '0;
    bit finished = 0;

    function automatic logic [31:0] dflt(input logic [24:0] a);
        return 32'hC0DE0000 ^ {7'b0, a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Reference model: decode pins, track timing, model memory
    always @(negedge clk) begin
        logic [3:0] cmd;
        if (rst_n) begin
            cyc++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (drvq.size() > 0 && drvq[0].due == cyc) begin
                sd_dq_in = drvq[0].d;
                void'(drvq.pop_front());
            end
            if (expq.size() > 0 && expq[0].due == cyc) begin
                chk(rd_valid === 1'b1, "R11", "rd_valid pulse", rd_valid, 1);
                chk(rd_data === expq[0].d, "R11", "read data", rd_data, expq[0].d);
                void'(expq.pop_front());
            end else if (rd_valid) chk(0, "R11", "stray rd_valid", 1, 0);
            if (sd_dq_oe !== (cmd == 4'b0100)) chk(0, "R10", "bus drive outside write", sd_dq_oe, 0);
            if (host_ready && (!mrs_seen || ref_seq || (cyc - last_ref < E_RC - 1)))
                chk(0, "R4", "ready while busy", 1, 0);
            if (cmd != 4'b0111 && after_mrs) begin
                chk(cyc - last_mrs >= E_MRD, "R3", "gap after mode set", cyc - last_mrs, E_MRD);
                after_mrs = 0;
            end
            case (cmd)
                4'b0111: ;
                4'b0010: begin
                    if (sd_addr[10]) begin
                        if (!first_done) begin
                            chk(cyc >= E_INIT, "R1", "power-up hold-off", cyc, E_INIT);
                            chk(sd_cke === 1'b1, "R1", "cke high", sd_cke, 1);
                            first_done = 1;
                        end else if (mrs_seen) ref_seq = 1;
                        chk(!open, "R9", "precharge-all with open row", open, 0);
                    end else begin
                        chk(open && sd_ba == open_ba, "R7", "precharge open bank", sd_ba, open_ba);
                        chk(cyc - last_act >= E_RAS, "R7", "tRAS", cyc - last_act, E_RAS);
                        chk(cyc - last_wr >= E_WR, "R7", "write recovery", cyc - last_wr, E_WR);
                        open = 0;
                    end
                    last_pre = cyc;
                end
                4'b0011: begin
                    chk(mrs_seen, "R2", "active before mode set", 0, 1);
                    chk(!open, "R8", "active with row open", open, 0);
                    chk(cyc - last_pre >= E_RP, "R8", "tRP", cyc - last_pre, E_RP);
                    chk(cyc - last_act >= E_RC, "R8", "tRC", cyc - last_act, E_RC);
                    chk(cyc - last_ref >= E_RC, "R9", "refresh recovery", cyc - last_ref, E_RC);
                    if (reqq.size() > 0) begin
                        chk(sd_addr == reqq[0].a[24:12], "R5", "row", sd_addr, reqq[0].a[24:12]);
                        chk(sd_ba == reqq[0].a[11:10], "R5", "bank", sd_ba, reqq[0].a[11:10]);
                    end else chk(0, "R5", "active with no request", 1, 0);
                    open = 1; open_ba = sd_ba; last_act = cyc;
                end
                4'b0100, 4'b0101: begin
                    req_t r;
                    chk(open && sd_ba == open_ba, "R6", "column to open bank", sd_ba, open_ba);
                    chk(cyc - last_act >= E_RCD, "R6", "tRCD", cyc - last_act, E_RCD);
                    chk(sd_addr[10] == 1'b0, "R6", "bit 10 low", sd_addr[10], 0);
                    if (reqq.size() > 0) begin
                        r = reqq.pop_front();
                        chk(sd_addr[9:0] == r.a[9:0], "R5", "column", sd_addr[9:0], r.a[9:0]);
                        chk((cmd == 4'b0100) == r.we, "R5", "direction", cmd, r.we);
                        if (cmd == 4'b0100) begin
                            logic [31:0] old;
                            chk(sd_dqm == ~r.be, "R10", "byte masks", sd_dqm, ~r.be);
                            chk(sd_dq_out == r.d, "R10", "write data", sd_dq_out, r.d);
                            old = mem.exists(r.a) ? mem[r.a] : dflt(r.a);
                            for (int b = 0; b < 4; b++)
                                if (!sd_dqm[b]) old[8*b +: 8] = sd_dq_out[8*b +: 8];
                            mem[r.a] = old;
                            last_wr = cyc;
                        end else begin
                            beat_t x;
                            chk(sd_dqm == 4'h0, "R11", "read masks low", sd_dqm, 0);
                            x.due = cyc + CL;
                            x.d = mem.exists(r.a) ? mem[r.a] : dflt(r.a);
                            drvq.push_back(x);
                            x.due = cyc + CL + 1;
                            x.d = sb.exists(r.a) ? sb[r.a] : dflt(r.a);
                            expq.push_back(x);
                        end
                    end else chk(0, "R5", "column with no request", 1, 0);
                end
                4'b0001: begin
                    chk(first_done, "R2", "refresh before precharge-all", 0, 1);
                    chk(cyc - last_pre >= E_RP, "R2", "tRP before refresh", cyc - last_pre, E_RP);
                    chk(cyc - last_ref >= E_RC, "R2", "refresh spacing", cyc - last_ref, E_RC);
                    chk(!open, "R9", "refresh with row open", open, 0);
                    if (!mrs_seen) init_refs++;
                    else begin
                        chk(ref_seq, "R9", "refresh without precharge-all", 0, 1);
                        chk(cyc - ref_anchor <= E_REFI + 40, "R9", "refresh interval",
                            cyc - ref_anchor, E_REFI);
                        ref_seq = 0; post_refs++; ref_anchor = cyc;
                    end
                    last_ref = cyc;
                end
                4'b0000: begin
                    chk(init_refs == 8, "R2", "refreshes before mode set", init_refs, 8);
                    chk(sd_addr == 13'(CL << 4), "R3", "mode word", sd_addr, CL << 4);
                    mrs_seen = 1; after_mrs = 1; last_mrs = cyc; ref_anchor = cyc;
                end
                default: chk(0, "R12", "illegal command code", cmd, 4'b0111);
            endcase
        end
    end

    task automatic do_req(input bit we, input logic [24:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        req_t r;
        @(negedge clk);
        host_valid = 1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
        #1;
        while (!host_ready) begin
            @(negedge clk);
            #1;
        end
        r.we = we; r.a = a; r.d = d; r.be = be;
        reqq.push_back(r);
        if (we) begin
            logic [31:0] v;
            v = sb.exists(a) ? sb[a] : dflt(a);
            for (int b = 0; b < 4; b++) if (be[b]) v[8*b +: 8] = d[8*b +: 8];
            sb[a] = v;
        end
        @(negedge clk);
        host_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        logic [15:0] lf;
        // R12: reset state
        repeat (5) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R12", "reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(sd_cke == 1'b0, "R12", "reset cke", sd_cke, 0);
        chk(!host_ready && !rd_valid && !sd_dq_oe, "R12", "reset outputs",
            {host_ready, rd_valid, sd_dq_oe}, 0);
        rst_n = 1;
        wait (mrs_seen);
        // Corner addresses and byte masking
        do_req(1, 25'h0, 32'h11223344, 4'hF);
        do_req(0, 25'h0, 0, 0);
        do_req(1, 25'h1FFFFFF, 32'hA5A55A5A, 4'hF);
        do_req(0, 25'h1FFFFFF, 0, 0);
        do_req(1, 25'h0, 32'hFFEEDDCC, 4'b0101);
        do_req(0, 25'h0, 0, 0);
        do_req(0, 25'h0ABCDE, 0, 0);
        for (int bk = 0; bk < 4; bk++)
            do_req(1, {13'h0155, 2'(bk), 10'h2AA}, 32'h1000 * (bk + 1), 4'hF);
        for (int bk = 0; bk < 4; bk++)
            do_req(0, {13'h0155, 2'(bk), 10'h2AA}, 0, 0);
        // Streaming traffic across refresh deadlines
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_req(lf[6], {11'h0, lf[1:0], lf[3:2], 8'h0, lf[5:4]}, {lf, ~lf}, lf[10:7]);
        end
        // Idle refresh
        repeat (2500) @(negedge clk);
        do_req(0, 25'h0, 0, 0);
        do_req(0, 25'h1FFFFFF, 0, 0);
        while (expq.size() > 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(post_refs >= 3, "R9", "refreshes after start-up", post_refs, 3);
        chk(reqq.size() == 0, "R5", "all requests served", reqq.size(), 0);
        finish_up();
    end
endmodule